// File: doc/BRIEF.md
# Masked Multi-Pin Output Compare

This block drives an 8-bit output port from a single compare channel. A 16-bit compare value is held in a register and checked against an external free-running counter. A match counts as a compare event only while the counter's tick input is high. On each event, a mask register selects the port bits that change. Every selected bit copies the matching bit of a dedicated data register. Unselected bits keep their present level. One event can therefore set, clear or leave alone several pins in the same clock cycle.

Software reaches the block over a byte-wide register bus. Writes are synchronous and reads are combinational. The bus holds the compare value (two bytes), the mask, the data register and the port latch itself. Only the top five bits of the data register exist. The port latch can be loaded directly, and the same byte reads it back. Writes to the mask or data register first affect the compare event that follows them. A direct port load that lands in the same cycle as an event gives way to the event on the masked bits.

Top module: `mpoc_top`

## Requirements
- R1: After reset, the compare value, mask, data register and port latch are all zero, and reading any of them returns 0x00. An event right after reset changes no port bit.
- R2: On a compare event, each port bit whose mask bit is 1 takes the value of the same bit of the data register.
- R3: On a compare event, each port bit whose mask bit is 0 keeps its previous value.
- R4: The data register is at bus address 0x0D. Only bits 7..3 store values. Bits 2..0 always read 0, so a masked port bit in positions 2..0 is driven to 0 on an event.
- R5: A compare event occurs only when cnt_tick is 1 and cnt_in equals the compare value. Without one, and without a port write, port_out does not change.
- R6: port_out changes at the rising clock edge that samples the compare event, and not before it.
- R7: A mask or data write in the same cycle as a compare event does not affect that event. The event uses the previous register values, and the new values serve the next event.
- R8: Address 0x03 is the port latch. A write loads port_out at the next edge. If a compare event occurs in the same cycle, masked bits take the data register value and unmasked bits take the written byte.
- R9: Reads return the compare high byte at 0x00, the compare low byte at 0x01, the mask at 0x02 and the port latch at 0x03. Any other address except 0x0D reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| cnt_in | input | 16 | Current value of the external counter |
| cnt_tick | input | 1 | High in cycles where the counter has advanced |
| port_out | output | 8 | Output port latch |

## Verification
The masked update is tried with complementary mask/data pairs, which show whether masked and unmasked bits are kept apart. It is also tried with masks that cover the unimplemented low data bits, which show the forced zeros. Matches without a tick, and ticks without a match, show whether the event really needs both conditions. Bus writes placed in the same cycle as an event separate old register values from new ones, and separate event priority from a direct port load. A seeded random run then mixes writes, ticks and matching counts, and a bitwise bench model checks every cycle.

// File: rtl/mpoc_pkg.sv
`timescale 1ns/1ps
package mpoc_pkg;
  localparam int BUS_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int OFS_CMP  = 0;   // compare value, most significant byte first
  localparam int OFS_MASK = 2;
  localparam int OFS_PORT = 3;
  localparam int OFS_DATA = 13;

  // Masked merge: selected bits from nxt, the rest from cur.
  function automatic logic [BUS_W-1:0] masked_merge(input logic [BUS_W-1:0] cur,
                                                    input logic [BUS_W-1:0] nxt,
                                                    input logic [BUS_W-1:0] sel);
    return (cur & ~sel) | (nxt & sel);
  endfunction
endpackage

// File: rtl/mpoc_regs.sv
`timescale 1ns/1ps
module mpoc_regs
  import mpoc_pkg::*;
#(
  parameter int              CMP_W     = 16,
  parameter logic [BUS_W-1:0] DATA_IMPL = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  port_q,
  output logic [CMP_W-1:0]  cmp_q,
  output logic [BUS_W-1:0]  mask_q,
  output logic [BUS_W-1:0]  data_q,
  output logic              port_wr,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int NB = CMP_W / BUS_W;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(OFS_PORT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic [NB-1:0][BUS_W-1:0] cmp_bytes;

  for (genvar k = 0; k < NB; k++) begin : g_cmp_byte
    localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(OFS_CMP + NB - 1 - k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cmp_bytes[k] <= '0;
      else if (bus_wr && bus_addr == A_BYTE) cmp_bytes[k] <= bus_wdata;
    end
  end

  assign cmp_q   = cmp_bytes;
  assign port_wr = bus_wr && (bus_addr == A_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      data_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MASK) mask_q <= bus_wdata;
      if (bus_addr == A_DATA) data_q <= bus_wdata & DATA_IMPL;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NB; k++)
      if (bus_addr == ADDR_W'(OFS_CMP + NB - 1 - k)) bus_rdata = cmp_bytes[k];
    if (bus_addr == A_MASK) bus_rdata = mask_q;
    if (bus_addr == A_PORT) bus_rdata = port_q;
    if (bus_addr == A_DATA) bus_rdata = data_q & DATA_IMPL;
  end
endmodule

// File: rtl/mpoc_match.sv
`timescale 1ns/1ps
module mpoc_match #(
  parameter int CMP_W = 16
) (
  input  logic [CMP_W-1:0] cnt_in,
  input  logic             cnt_tick,
  input  logic [CMP_W-1:0] cmp_q,
  output logic             cmp_event
);
  assign cmp_event = cnt_tick && (cnt_in == cmp_q);
endmodule

// File: rtl/mpoc_port.sv
`timescale 1ns/1ps
module mpoc_port
  import mpoc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_event,
  input  logic             port_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic [BUS_W-1:0] mask_q,
  input  logic [BUS_W-1:0] data_q,
  output logic [BUS_W-1:0] port_q
);
  logic [BUS_W-1:0] base_val;
  logic [BUS_W-1:0] port_nxt;

  always_comb begin
    base_val = port_wr ? bus_wdata : port_q;
    port_nxt = cmp_event ? masked_merge(base_val, data_q, mask_q) : base_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= '0;
    else        port_q <= port_nxt;
  end
endmodule

// File: rtl/mpoc_top.sv
`timescale 1ns/1ps
module mpoc_top
  import mpoc_pkg::*;
#(
  parameter int               CMP_W     = 16,
  parameter logic [BUS_W-1:0] DATA_IMPL = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CMP_W-1:0]  cnt_in,
  input  logic              cnt_tick,
  output logic [BUS_W-1:0]  port_out
);
  logic [CMP_W-1:0] cmp_q;
  logic [BUS_W-1:0] mask_q;
  logic [BUS_W-1:0] data_q;
  logic             port_wr;
  logic             cmp_event;

  mpoc_regs #(.CMP_W(CMP_W), .DATA_IMPL(DATA_IMPL)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .port_q(port_out), .cmp_q(cmp_q),
    .mask_q(mask_q), .data_q(data_q), .port_wr(port_wr), .bus_rdata(bus_rdata)
  );

  mpoc_match #(.CMP_W(CMP_W)) u_match (
    .cnt_in(cnt_in), .cnt_tick(cnt_tick), .cmp_q(cmp_q), .cmp_event(cmp_event)
  );

  mpoc_port u_port (
    .clk(clk), .rst_n(rst_n), .cmp_event(cmp_event), .port_wr(port_wr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .data_q(data_q), .port_q(port_out)
  );
endmodule

// File: rtl/mpoc_checker.sv
`timescale 1ns/1ps
module mpoc_checker
  import mpoc_pkg::*;
#(
  parameter int               CMP_W     = 16,
  parameter logic [BUS_W-1:0] DATA_IMPL = 8'hF8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [CMP_W-1:0]  cnt_in,
  input logic              cnt_tick,
  input logic [CMP_W-1:0]  cmp_q,
  input logic [BUS_W-1:0]  mask_q,
  input logic [BUS_W-1:0]  data_q,
  input logic              port_wr,
  input logic              cmp_event,
  input logic [BUS_W-1:0]  port_out
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (port_out == '0 && mask_q == '0 && data_q == '0 && cmp_q == '0));

  assert_masked_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |=> ((port_out & $past(mask_q)) == ($past(data_q) & $past(mask_q))));

  assert_unmasked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_event && !port_wr) |=>
      ((port_out & ~$past(mask_q)) == ($past(port_out) & ~$past(mask_q))));

  assert_data_low_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_DATA)) |-> ((bus_rdata & ~DATA_IMPL) == '0));

  assert_event_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |-> (cnt_tick && cnt_in == cmp_q));

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_event && !port_wr) |=> $stable(port_out));

  assert_write_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_event && port_wr) |=>
      ((port_out & ~$past(mask_q)) == ($past(bus_wdata) & ~$past(mask_q))));
endmodule

bind mpoc_top mpoc_checker #(.CMP_W(CMP_W), .DATA_IMPL(DATA_IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cnt_in(cnt_in), .cnt_tick(cnt_tick), .cmp_q(cmp_q),
  .mask_q(mask_q), .data_q(data_q), .port_wr(port_wr), .cmp_event(cmp_event),
  .port_out(port_out)
);

// File: tb/mpoc_top_bench.sv
`timescale 1ns/1ps
module mpoc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_in = '0;
  logic        cnt_tick = 1'b0;
  logic [7:0]  port_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_cmp = '0;
  logic [7:0]  m_mask = '0, m_data = '0, m_port = '0;

  always #2.5 clk = ~clk;

  mpoc_top u_mpoc_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
    .cnt_tick(cnt_tick), .port_out(port_out)
  );

  function automatic logic [7:0] bit_pick(input logic [7:0] cur, input logic [7:0] d,
                                          input logic [7:0] m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m[i] ? d[i] : cur[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_cmp[15:8];
      4'h1: return m_cmp[7:0];
      4'h2: return m_mask;
      4'h3: return m_port;
      4'hD: return m_data;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One bus/counter cycle; the port is checked just before and just after the edge.
  task automatic cyc(input string req, input logic wr, input logic [3:0] a,
                     input logic [7:0] d, input logic [15:0] cnt, input logic tk);
    logic ev;
    logic [7:0] nxt;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_in = cnt; cnt_tick = tk;
    ev  = tk && (cnt == m_cmp);
    nxt = (wr && a == 4'h3) ? d : m_port;
    if (ev) nxt = bit_pick(nxt, m_data, m_mask);
    #1 check8("R6 before edge", port_out, m_port);
    @(posedge clk);
    #1;
    bus_wr = 1'b0; cnt_tick = 1'b0;
    m_port = nxt;
    if (wr) begin
      case (a)
        4'h0: m_cmp[15:8] = d;
        4'h1: m_cmp[7:0]  = d;
        4'h2: m_mask      = d;
        4'hD: m_data      = d & 8'hF8;
        default: ;
      endcase
    end
    check8(req, port_out, m_port);
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check8(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc("R8 write cycle", 1'b1, a, d, 16'hFFFF, 1'b0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20511);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd("R1 cmp hi", 4'h0, 8'h00);
    rd("R1 cmp lo", 4'h1, 8'h00);
    rd("R1 mask", 4'h2, 8'h00);
    rd("R1 port", 4'h3, 8'h00);
    rd("R1 data", 4'hD, 8'h00);
    cyc("R1 event after reset", 1'b0, 4'h0, 8'h00, 16'h0000, 1'b1);

    // R4: unimplemented data bits
    wr(4'hD, 8'hFF);
    rd("R4 data readback", 4'hD, 8'hF8);

    // R2 and R9: basic masked update and register readback
    wr(4'h0, 8'h12); wr(4'h1, 8'h34); wr(4'h2, 8'hF0);
    rd("R9 cmp hi", 4'h0, 8'h12);
    rd("R9 cmp lo", 4'h1, 8'h34);
    rd("R9 mask", 4'h2, 8'hF0);
    rd("R9 unmapped", 4'h5, 8'h00);
    cyc("R2 masked set", 1'b0, 4'h0, 8'h00, 16'h1234, 1'b1);
    check8("R2 value", port_out, 8'hF0);

    // R5: match without tick, tick without match
    cyc("R5 no tick", 1'b0, 4'h0, 8'h00, 16'h1234, 1'b0);
    wr(4'h3, 8'h0F);
    wr(4'hD, 8'h00);
    cyc("R5 no match", 1'b0, 4'h0, 8'h00, 16'h1235, 1'b1);
    check8("R5 value", port_out, 8'h0F);

    // R3: unmasked bits hold
    wr(4'h3, 8'h5A);
    wr(4'hD, 8'hF8);
    cyc("R3 unmasked keep", 1'b0, 4'h0, 8'h00, 16'h1234, 1'b1);
    check8("R3 value", port_out, 8'hFA);

    // R4: masked low bits driven to zero
    wr(4'h2, 8'h07); wr(4'h3, 8'hFF); wr(4'hD, 8'hFF);
    cyc("R4 low bits cleared", 1'b0, 4'h0, 8'h00, 16'h1234, 1'b1);
    check8("R4 value", port_out, 8'hF8);

    // R7: register writes coinciding with an event use old values
    wr(4'h2, 8'hFF); wr(4'hD, 8'h00); wr(4'h3, 8'hAA);
    cyc("R7 data write with event", 1'b1, 4'hD, 8'hF8, 16'h1234, 1'b1);
    check8("R7 old data used", port_out, 8'h00);
    cyc("R7 next event new data", 1'b0, 4'h0, 8'h00, 16'h1234, 1'b1);
    check8("R7 new data used", port_out, 8'hF8);
    cyc("R7 mask write with event", 1'b1, 4'h2, 8'h00, 16'h1234, 1'b1);
    wr(4'hD, 8'h00);
    cyc("R7 zero mask next", 1'b0, 4'h0, 8'h00, 16'h1234, 1'b1);
    check8("R7 new mask used", port_out, 8'hF8);

    // R8: port write and event in the same cycle
    wr(4'h2, 8'hF0); wr(4'hD, 8'hA0);
    cyc("R8 write plus event", 1'b1, 4'h3, 8'h5F, 16'h1234, 1'b1);
    check8("R8 value", port_out, 8'hAF);

    // Random mix, checked against the bench model
    for (int n = 0; n < 600; n++) begin
      logic [3:0] a;
      logic [15:0] c;
      case ($urandom % 6)
        0: a = 4'h0;
        1: a = 4'h1;
        2: a = 4'h2;
        3: a = 4'h3;
        4: a = 4'hD;
        default: a = 4'h6;
      endcase
      c = ($urandom % 2) ? m_cmp : 16'($urandom);
      cyc("R2 R3 random", ($urandom % 3) == 0, a, 8'($urandom), c, 1'($urandom));
      if (($urandom % 4) == 0) rd("R9 random read", a, exp_read(a));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule